// File: doc/BRIEF.md
# Prefixed Opcode Fetch Sequencer

This block sits in the fetch stage of an 8-bit processor core. It pulls instruction bytes one at a time over a valid/ready byte port, walks through the escape bytes CB, DD, ED and FD, and hands the execute stage a single decoded record for each instruction. The record holds the opcode table to use, the final opcode byte, a sign-extended displacement, and the number of extra cycles the escape bytes cost.

The two indexed-bit forms (DD CB and FD CB) are unusual because the signed displacement arrives before the final opcode. The sequencer captures the displacement, then the opcode. When an index escape is directly followed by another index escape, the first one is retired as a no-op, and the second escape byte is decoded again as the start of a new instruction. The fetch address is a 16-bit program counter that wraps around. A 7-bit refresh counter advances once for every instruction start.

The escape byte values are part of the behaviour: CB selects the bit table, ED the extended table, DD the first index table and FD the second index table. Parameter `DISP_W` must be greater than 8.

Top module: `opfetch_seq`

## Requirements
- R1: Reset leaves the outputs in a known state: `fetch_addr` = 0, `refresh` = 0 and `dec_valid` = 0. `byte_ready` goes to 1 within a few cycles after `rst_n` is released.
- R2: A first byte that is not CB, DD, ED or FD is decoded with table code 0 (base). The opcode is that byte, the overhead is 0 and the displacement is 0.
- R3: CB followed by byte X decodes with table code 1, and ED followed by X decodes with table code 3. In both cases the opcode is X and the overhead is 4.
- R4: DD or FD followed by a byte X other than CB, DD or FD decodes with table code 2 (after DD) or 4 (after FD). The opcode is X, the overhead is 4 and the displacement is 0.
- R5: DD CB d X decodes with table code 5 and FD CB d X with table code 6. The third byte d is the displacement, the fourth byte X is the opcode, and the overhead is 8.
- R6: The displacement is d sign-extended to `DISP_W` bits. When bit 7 of d is set, the value is d minus 256, taken modulo 2^DISP_W.
- R7: DD or FD followed by DD or FD decodes as a no-op: table code 7, opcode 0, overhead 4. The program counter is left pointing at the second escape byte, so that byte begins a new decode.
- R8: `refresh` increments by one, modulo 128, for every instruction start, including the restart after a no-op. It does not change otherwise.
- R9: `fetch_addr` increments by one, modulo 65536, for every accepted byte, except in the R7 rewind case. It holds when no byte is accepted.
- R10: `dec_valid` pulses in the cycle after the final byte of an instruction is accepted. The decoded fields are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| byte_valid | input | 1 | The byte at `fetch_addr` is present on `byte_data` |
| byte_data | input | 8 | Instruction byte |
| byte_ready | output | 1 | Sequencer accepts a byte in this cycle |
| fetch_addr | output | ADDR_W | Program counter, the address of the next byte |
| dec_valid | output | 1 | Decoded record strobe |
| dec_table | output | 3 | Opcode table code (0 to 7, see R2 to R7) |
| dec_opcode | output | 8 | Final opcode byte |
| dec_disp | output | DISP_W | Sign-extended displacement |
| dec_cycles | output | CYC_W | Escape-byte cycle overhead |
| refresh | output | REF_W | Refresh counter |

## Verification
The checks assume that `byte_data` always holds the memory byte at the current `fetch_addr` whenever `byte_valid` is high. They also assume that the memory image does not change while the run is in progress. The bench guarantees this by driving `byte_data` directly from a fixed memory image indexed by `fetch_addr`.

`byte_valid` is dropped in a repeating pattern that includes single-cycle gaps and longer gaps, so stalls land at every position inside an instruction. The image covers every base byte, every byte after CB, ED, DD and FD, and all 256 displacements for both indexed-bit forms. It also includes chains of index escapes. The rest of the image is base opcodes, and the run continues through the wrap of the program counter.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam logic [7:0] ESC_BIT = 8'hCB;
  localparam logic [7:0] ESC_IX  = 8'hDD;
  localparam logic [7:0] ESC_EXT = 8'hED;
  localparam logic [7:0] ESC_IY  = 8'hFD;

  typedef enum logic [2:0] {
    TBL_BASE  = 3'd0,
    TBL_BIT   = 3'd1,
    TBL_IX    = 3'd2,
    TBL_EXT   = 3'd3,
    TBL_IY    = 3'd4,
    TBL_IXBIT = 3'd5,
    TBL_IYBIT = 3'd6,
    TBL_NOP   = 3'd7
  } tbl_e;

  typedef enum logic [1:0] {
    ST_HEAD,
    ST_SECOND,
    ST_DISP,
    ST_TAIL
  } st_e;

  function automatic logic is_index_esc(input logic [7:0] b);
    return (b == ESC_IX) || (b == ESC_IY);
  endfunction
endpackage

// File: rtl/opf_rst_sync.sv
module opf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/opf_counters.sv
module opf_counters #(
  parameter int ADDR_W = 16,
  parameter int REF_W  = 7
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              acc,
  input  logic              hold,
  input  logic              start,
  output logic [ADDR_W-1:0] pc,
  output logic [REF_W-1:0]  refr
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [REF_W-1:0]  ref_q, ref_d;
  logic              pc_en, ref_en;

  always_comb begin
    pc_en  = acc && !hold;
    ref_en = start;
    pc_d   = pc_q + ADDR_W'(1);
    ref_d  = ref_q + REF_W'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pc_q  <= '0;
      ref_q <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (ref_en) ref_q <= ref_d;
    end
  end

  assign pc   = pc_q;
  assign refr = ref_q;
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
#(
  parameter int DISP_W  = 16,
  parameter int CYC_W   = 4,
  parameter int PFX_CYC = 4,
  parameter int DBL_CYC = 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              acc,
  input  logic [7:0]        byte_in,
  output logic              start,
  output logic              hold,
  output logic              dec_valid,
  output logic [2:0]        dec_table,
  output logic [7:0]        dec_opcode,
  output logic [DISP_W-1:0] dec_disp,
  output logic [CYC_W-1:0]  dec_cycles
);
  localparam int EXT_W = DISP_W - 8;

  st_e               st_q, st_d;
  tbl_e              pend_q, pend_d;
  logic [7:0]        dsp_q, dsp_d;
  logic              emit;
  tbl_e              emit_tbl;
  logic [7:0]        emit_op;
  logic [DISP_W-1:0] emit_disp;
  logic [CYC_W-1:0]  emit_cyc;
  logic              pend_idx;

  logic              val_q;
  tbl_e              tbl_q;
  logic [7:0]        op_q;
  logic [DISP_W-1:0] disp_q;
  logic [CYC_W-1:0]  cyc_q;

  assign pend_idx = (pend_q == TBL_IX) || (pend_q == TBL_IY);

  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    dsp_d     = dsp_q;
    emit      = 1'b0;
    emit_tbl  = TBL_BASE;
    emit_op   = byte_in;
    emit_disp = '0;
    emit_cyc  = '0;
    start     = 1'b0;
    hold      = 1'b0;
    if (acc) begin
      unique case (st_q)
        ST_HEAD: begin
          start = 1'b1;
          if (byte_in == ESC_BIT) begin
            pend_d = TBL_BIT;
            st_d   = ST_SECOND;
          end else if (byte_in == ESC_EXT) begin
            pend_d = TBL_EXT;
            st_d   = ST_SECOND;
          end else if (byte_in == ESC_IX) begin
            pend_d = TBL_IX;
            st_d   = ST_SECOND;
          end else if (byte_in == ESC_IY) begin
            pend_d = TBL_IY;
            st_d   = ST_SECOND;
          end else begin
            emit = 1'b1;
          end
        end
        ST_SECOND: begin
          if (pend_idx && is_index_esc(byte_in)) begin
            emit     = 1'b1;
            emit_tbl = TBL_NOP;
            emit_op  = 8'h00;
            emit_cyc = CYC_W'(PFX_CYC);
            hold     = 1'b1;
            st_d     = ST_HEAD;
          end else if (pend_idx && (byte_in == ESC_BIT)) begin
            pend_d = (pend_q == TBL_IX) ? TBL_IXBIT : TBL_IYBIT;
            st_d   = ST_DISP;
          end else begin
            emit     = 1'b1;
            emit_tbl = pend_q;
            emit_cyc = CYC_W'(PFX_CYC);
            st_d     = ST_HEAD;
          end
        end
        ST_DISP: begin
          dsp_d = byte_in;
          st_d  = ST_TAIL;
        end
        ST_TAIL: begin
          emit      = 1'b1;
          emit_tbl  = pend_q;
          emit_cyc  = CYC_W'(DBL_CYC);
          emit_disp = {{EXT_W{dsp_q[7]}}, dsp_q};
          st_d      = ST_HEAD;
        end
        default: st_d = ST_HEAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_HEAD;
      pend_q <= TBL_BASE;
      dsp_q  <= '0;
      val_q  <= 1'b0;
      tbl_q  <= TBL_BASE;
      op_q   <= '0;
      disp_q <= '0;
      cyc_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      dsp_q  <= dsp_d;
      val_q  <= emit;
      if (emit) begin
        tbl_q  <= emit_tbl;
        op_q   <= emit_op;
        disp_q <= emit_disp;
        cyc_q  <= emit_cyc;
      end
    end
  end

  assign dec_valid  = val_q;
  assign dec_table  = tbl_q;
  assign dec_opcode = op_q;
  assign dec_disp   = disp_q;
  assign dec_cycles = cyc_q;
endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq #(
  parameter int ADDR_W  = 16,
  parameter int REF_W   = 7,
  parameter int DISP_W  = 16,
  parameter int CYC_W   = 4,
  parameter int PFX_CYC = 4,
  parameter int DBL_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              byte_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              dec_valid,
  output logic [2:0]        dec_table,
  output logic [7:0]        dec_opcode,
  output logic [DISP_W-1:0] dec_disp,
  output logic [CYC_W-1:0]  dec_cycles,
  output logic [REF_W-1:0]  refresh
);
  logic srst_n;
  logic rdy_q;
  logic acc;
  logic start;
  logic hold;

  opf_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rdy_q <= 1'b0;
    else         rdy_q <= 1'b1;
  end

  assign byte_ready = rdy_q;
  assign acc        = byte_valid && rdy_q;

  opf_ctrl #(
    .DISP_W  (DISP_W),
    .CYC_W   (CYC_W),
    .PFX_CYC (PFX_CYC),
    .DBL_CYC (DBL_CYC)
  ) u_ctrl (
    .clk        (clk),
    .srst_n     (srst_n),
    .acc        (acc),
    .byte_in    (byte_data),
    .start      (start),
    .hold       (hold),
    .dec_valid  (dec_valid),
    .dec_table  (dec_table),
    .dec_opcode (dec_opcode),
    .dec_disp   (dec_disp),
    .dec_cycles (dec_cycles)
  );

  opf_counters #(
    .ADDR_W (ADDR_W),
    .REF_W  (REF_W)
  ) u_cnt (
    .clk    (clk),
    .srst_n (srst_n),
    .acc    (acc),
    .hold   (hold),
    .start  (start),
    .pc     (fetch_addr),
    .refr   (refresh)
  );
endmodule

// File: rtl/opfetch_seq_chk.sv
module opfetch_seq_chk #(
  parameter int ADDR_W  = 16,
  parameter int REF_W   = 7,
  parameter int DISP_W  = 16,
  parameter int CYC_W   = 4,
  parameter int PFX_CYC = 4,
  parameter int DBL_CYC = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_valid,
  input logic [7:0]        byte_data,
  input logic              byte_ready,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              dec_valid,
  input logic [2:0]        dec_table,
  input logic [7:0]        dec_opcode,
  input logic [DISP_W-1:0] dec_disp,
  input logic [CYC_W-1:0]  dec_cycles,
  input logic [REF_W-1:0]  refresh
);
  logic took;
  logic is_pfx_tbl;
  logic is_dbl_tbl;

  assign took       = byte_valid && byte_ready;
  assign is_pfx_tbl = (dec_table inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd7});
  assign is_dbl_tbl = (dec_table inside {3'd5, 3'd6});

  AST_STROBE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(took)) else $error("strobe without byte"); // R10

  AST_PC_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !took |=> $stable(fetch_addr)) else $error("pc moved while idle"); // R9

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> (fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1)) ||
             (dec_valid && (dec_table == 3'd7) && $stable(fetch_addr)))
    else $error("pc step wrong"); // R7

  AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh != $past(refresh)) |-> (refresh == REF_W'($past(refresh) + 1'b1)))
    else $error("refresh jump"); // R8

  AST_REF_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh != $past(refresh)) |-> $past(took)) else $error("refresh without byte"); // R8

  AST_BASE_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && (dec_table == 3'd0)) |-> (dec_cycles == '0) && (dec_disp == '0))
    else $error("base record wrong"); // R2

  AST_PFX_OVERHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && is_pfx_tbl) |-> (dec_cycles == CYC_W'(PFX_CYC)))
    else $error("escape overhead wrong"); // R3

  AST_DBL_OVERHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && is_dbl_tbl) |-> (dec_cycles == CYC_W'(DBL_CYC)))
    else $error("double escape overhead wrong"); // R5

  AST_DISP_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ((dec_disp[DISP_W-1:7] == '0) || (dec_disp[DISP_W-1:7] == '1)))
    else $error("displacement not sign-extended"); // R6

  AST_DISP_ONLY_DBL: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !is_dbl_tbl) |-> (dec_disp == '0)) else $error("stray displacement"); // R4

  AST_NOP_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && (dec_table == 3'd7)) |-> (dec_opcode == 8'h00))
    else $error("no-op opcode wrong"); // R7
endmodule

bind opfetch_seq opfetch_seq_chk #(
  .ADDR_W  (ADDR_W),
  .REF_W   (REF_W),
  .DISP_W  (DISP_W),
  .CYC_W   (CYC_W),
  .PFX_CYC (PFX_CYC),
  .DBL_CYC (DBL_CYC)
) u_chk (.*);

// File: tb/opfetch_seq_test.sv
module opfetch_seq_test;
  localparam int AW = 16;
  localparam int RW = 7;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int WDOG = 180000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          byte_valid;
  logic [7:0]    byte_data;
  logic          byte_ready;
  logic [AW-1:0] fetch_addr;
  logic          dec_valid;
  logic [2:0]    dec_table;
  logic [7:0]    dec_opcode;
  logic [DW-1:0] dec_disp;
  logic [CW-1:0] dec_cycles;
  logic [RW-1:0] refresh;

  always #4 clk = ~clk;

  logic [7:0] mem [0:65535];
  assign byte_data = mem[fetch_addr];

  opfetch_seq uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_ready (byte_ready),
    .fetch_addr (fetch_addr),
    .dec_valid  (dec_valid),
    .dec_table  (dec_table),
    .dec_opcode (dec_opcode),
    .dec_disp   (dec_disp),
    .dec_cycles (dec_cycles),
    .refresh    (refresh)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  logic [15:0] wp;
  task automatic put(input logic [7:0] b);
    mem[wp] = b;
    wp = wp + 16'd1;
  endtask

  logic [15:0] mpc;
  logic [6:0]  mref;
  int          e_tbl, e_op, e_disp, e_cyc;
  bit          wrapped;
  string       e_tag;

  task automatic model_step();
    logic [7:0]  b0, b1, d;
    logic [15:0] old;
    old    = mpc;
    e_disp = 0;
    b0     = mem[mpc];
    mpc    = mpc + 16'd1;
    if (b0 == 8'hCB || b0 == 8'hED) begin
      e_op  = mem[mpc];
      mpc   = mpc + 16'd1;
      e_tbl = (b0 == 8'hCB) ? 1 : 3;
      e_cyc = 4;
      e_tag = "R3";
    end else if (b0 == 8'hDD || b0 == 8'hFD) begin
      b1 = mem[mpc];
      if (b1 == 8'hDD || b1 == 8'hFD) begin
        e_tbl = 7; e_op = 0; e_cyc = 4; e_tag = "R7";
      end else if (b1 == 8'hCB) begin
        mpc   = mpc + 16'd1;
        d     = mem[mpc];
        mpc   = mpc + 16'd1;
        e_op  = mem[mpc];
        mpc   = mpc + 16'd1;
        e_tbl = (b0 == 8'hDD) ? 5 : 6;
        e_cyc = 8;
        e_disp = (d >= 128) ? (65536 - 256 + int'(d)) : int'(d);
        e_tag = (d >= 128) ? "R6" : "R5";
      end else begin
        mpc   = mpc + 16'd1;
        e_op  = b1;
        e_tbl = (b0 == 8'hDD) ? 2 : 4;
        e_cyc = 4;
        e_tag = "R4";
      end
    end else begin
      e_tbl = 0; e_op = b0; e_cyc = 0; e_tag = "R2";
    end
    mref = mref + 7'd1;
    if (mpc < old) wrapped = 1'b1;
  endtask

  initial begin
    int  cyc;
    int  extra;
    bit  prev_acc;
    bit  done;
    bit  seen_wrap_chk;
    rst_n      = 1'b0;
    byte_valid = 1'b0;
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    wp = 16'd0;
    for (int b = 0; b < 256; b++)
      if (!(b inside {8'hCB, 8'hDD, 8'hED, 8'hFD})) put(8'(b));
    for (int x = 0; x < 256; x++) begin
      put(8'hCB); put(8'(x));
      put(8'hED); put(8'(x));
    end
    for (int x = 0; x < 256; x++)
      if (!(x inside {8'hCB, 8'hDD, 8'hFD})) begin
        put(8'hDD); put(8'(x));
        put(8'hFD); put(8'(x));
      end
    for (int d = 0; d < 256; d++) begin
      put(8'hDD); put(8'hCB); put(8'(d)); put(8'(d) ^ 8'h5A);
      put(8'hFD); put(8'hCB); put(8'(d)); put(8'(d) ^ 8'hA5);
    end
    put(8'hDD); put(8'hDD); put(8'h77);
    put(8'hDD); put(8'hFD); put(8'h21);
    put(8'hFD); put(8'hDD); put(8'hCB); put(8'h80); put(8'h46);
    put(8'hFD); put(8'hFD); put(8'hFD); put(8'h09);
    put(8'hDD); put(8'hDD); put(8'hDD); put(8'hCB); put(8'h7F); put(8'hFE);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "fetch_addr", int'(fetch_addr), 0);
    chk("R1", "refresh", int'(refresh), 0);
    chk("R1", "dec_valid", int'(dec_valid), 0);
    chk("R1", "byte_ready", int'(byte_ready), 1);

    mpc = 16'd0; mref = 7'd0; wrapped = 1'b0;
    cyc = 0; extra = 0; prev_acc = 1'b0; done = 1'b0; seen_wrap_chk = 1'b0;
    while (!done) begin
      if (dec_valid) begin
        chk("R10", "byte accepted before strobe", int'(prev_acc), 1);
        model_step();
        chk(e_tag, "table", int'(dec_table), e_tbl);
        chk(e_tag, "opcode", int'(dec_opcode), e_op);
        chk(e_tag, "disp", int'(dec_disp), e_disp);
        chk(e_tag, "cycles", int'(dec_cycles), e_cyc);
        chk((e_tbl == 7) ? "R7" : "R9", "fetch_addr", int'(fetch_addr), int'(mpc));
        chk("R8", "refresh", int'(refresh), int'(mref));
        if (wrapped) begin
          extra++;
          if (!seen_wrap_chk) begin
            seen_wrap_chk = 1'b1;
            chk("R9", "fetch_addr after wrap", int'(fetch_addr), int'(mpc));
          end
        end
      end
      byte_valid = !(((cyc % 5) == 3) || ((cyc % 97) < 3));
      prev_acc   = byte_valid && byte_ready;
      @(negedge clk);
      cyc++;
      if (wrapped && extra >= 1500) done = 1'b1;
      if (cyc > WDOG) begin
        fails++;
        checks++;
        $display("FAIL R9 watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
        done = 1'b1;
      end
    end
    chk("R9", "program counter wrapped", int'(wrapped), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule